// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Level and Edge Interrupts

This block is a general-purpose I/O controller for a configurable number of pins, up to 32. Software reaches it through a 32-bit register port with APB-style timing. A transfer is selected in one cycle, and it is accepted in the following cycle while `penable` is high. The block adds no wait states. For each pin, software sets the direction, an output enable and an output level. A bypass bit hands the pad to an alternate-function path instead of the GPIO registers. A two-flop synchronizer feeds the pin input to a readable input register and to the interrupt logic.

Each pin raises a pending bit from one of four conditions: a level that matches a polarity bit, a rising edge, a falling edge, or any edge. Software changes the interrupt mask only through two write-one registers. A bit written to the enable register unmasks that pin, and a bit written to the disable register masks it. There is no acknowledge register. A read of the status register returns every pending bit and clears them in the same transfer. One combined output, `irq_o`, reports any pending bit that is not masked.

The register offsets are: bypass 0x00, direction 0x04, output enable 0x08, output value 0x0C, input value 0x10, mask 0x14, enable 0x18, disable 0x1C, status 0x20, type 0x24, polarity 0x28, any-edge 0x2C. The enable and disable registers read as zero. Writes to the input value, mask and status registers are ignored.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, the mask reads all ones over the implemented pins and the direction reads all ones, so every pin is an input. Every other register reads zero, `irq_o` is 0 and `pin_oe` is 0.
- R2: Register bits at and above NPINS read as zero, and writes to them are ignored. A write of 0xFFFFFFFF to bypass reads back as 0x0000FFFF when NPINS is 16.
- R3: For a pin whose bypass bit is 0, `pin_oe` is 1 only when its direction bit is 0 and its output-enable bit is 1, and `pin_out` equals its output-value bit.
- R4: For a pin whose bypass bit is 1, `pin_out` and `pin_oe` follow `alt_out` and `alt_oe`, and `alt_in` carries `pin_in`. `alt_in` is 0 for a pin whose bypass bit is 0.
- R5: A change on `pin_in` appears in the input value register after two clock edges.
- R6: Writing 1 to a bit of the enable register clears that mask bit. Writing 1 to a bit of the disable register sets it. Writing 0 to either register leaves the mask unchanged.
- R7: `irq_o` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R8: With type bit 1, which selects level sensitivity, the pin becomes pending while its synchronized level equals its polarity bit: 1 means high and 0 means low. A level that is still active sets its bit again on the cycle after a status read.
- R9: With type bit 0, which selects edge sensitivity, an any-edge bit of 1 sets the pin pending on both edges. Otherwise a polarity bit of 1 sets it on a rising edge and 0 on a falling edge. An edge is reported only once.
- R10: A status read returns the pending bits and clears them. A bit set by a condition detected in the same cycle as the read stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Register transfer select |
| penable | input | 1 | Register transfer access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address (word aligned) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad drive enables |
| alt_out | input | NPINS | Alternate-function output levels |
| alt_oe | input | NPINS | Alternate-function drive enables |
| alt_in | output | NPINS | Pad levels passed to the alternate function |
| irq_o | output | 1 | Combined unmasked interrupt |

## Verification
The assertions assume a well-formed register port. A transfer holds `psel` high through a setup cycle and then an access cycle. It keeps the address and data stable across both cycles, and it never writes the enable and disable registers in the same cycle. The stimulus drives every transfer at falling edges in exactly that two-cycle shape, and it leaves the bus idle between transfers. Pin levels change only at falling edges and are then held for several cycles. The only exception is one deliberate case, in which an edge lands on the very cycle of a status read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [3:0] {
    RG_BYP  = 4'd0,
    RG_DIR  = 4'd1,
    RG_OE   = 4'd2,
    RG_OUT  = 4'd3,
    RG_IN   = 4'd4,
    RG_MASK = 4'd5,
    RG_EN   = 4'd6,
    RG_DIS  = 4'd7,
    RG_STAT = 4'd8,
    RG_TYPE = 4'd9,
    RG_POL  = 4'd10,
    RG_ANY  = 4'd11
  } reg_idx_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [1:0]   age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic is_level,
  input  logic pol,
  input  logic both,
  input  logic clr,
  output logic pend
);
  logic prev;
  logic rise, fall, hit;

  always_comb begin
    rise = lvl & ~prev;
    fall = ~lvl & prev;
    if (is_level)  hit = (lvl == pol);
    else if (both) hit = rise | fall;
    else           hit = pol ? rise : fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= lvl;
      pend <= (pend & ~clr) | hit;
    end
  end

  a_r10_hit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !pend);
  a_r9_no_edge_when_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && !pend && (lvl == prev)) |=> !pend);
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 16
) (
  input  logic [W-1:0] byp,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] oe,
  input  logic [W-1:0] outv,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] alt_in
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (byp[i]) begin
        pin_out[i] = alt_out[i];
        pin_oe[i]  = alt_oe[i];
        alt_in[i]  = pin_in[i];
      end else begin
        pin_out[i] = outv[i];
        pin_oe[i]  = oe[i] & ~dir[i];
        alt_in[i]  = 1'b0;
      end
    end
  end

  always_comb begin
    a_r3_input_undriven: assert ((pin_oe & ~byp & dir) == '0);
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  alt_in,
  output logic              irq_o
);
  import gpio_pkg::*;

  localparam int N = NPINS;

  logic [N-1:0] r_byp, r_dir, r_oe, r_out, r_mask, r_type, r_pol, r_any;
  logic [N-1:0] sync_in, pend;
  logic [N-1:0] wd;
  logic [N-1:0] rd_val;
  logic [3:0]   idx;
  logic         acc, wr, rd_stat;

  assign idx     = paddr[5:2];
  assign acc     = psel & penable;
  assign wr      = acc & pwrite;
  assign rd_stat = acc & ~pwrite & (idx == RG_STAT);
  assign wd      = pwdata[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_byp  <= '0;
      r_dir  <= '1;
      r_oe   <= '0;
      r_out  <= '0;
      r_mask <= '1;
      r_type <= '0;
      r_pol  <= '0;
      r_any  <= '0;
    end else if (wr) begin
      case (idx)
        RG_BYP:  r_byp  <= wd;
        RG_DIR:  r_dir  <= wd;
        RG_OE:   r_oe   <= wd;
        RG_OUT:  r_out  <= wd;
        RG_EN:   r_mask <= r_mask & ~wd;
        RG_DIS:  r_mask <= r_mask | wd;
        RG_TYPE: r_type <= wd;
        RG_POL:  r_pol  <= wd;
        RG_ANY:  r_any  <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      RG_BYP:  rd_val = r_byp;
      RG_DIR:  rd_val = r_dir;
      RG_OE:   rd_val = r_oe;
      RG_OUT:  rd_val = r_out;
      RG_IN:   rd_val = sync_in;
      RG_MASK: rd_val = r_mask;
      RG_STAT: rd_val = pend;
      RG_TYPE: rd_val = r_type;
      RG_POL:  rd_val = r_pol;
      RG_ANY:  rd_val = r_any;
      default: rd_val = '0;
    endcase
    prdata = '0;
    if (acc && !pwrite) prdata[N-1:0] = rd_val;
  end

  gpio_sync #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in)
  );

  for (genvar i = 0; i < N; i++) begin : g_irq
    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n), .lvl(sync_in[i]), .is_level(r_type[i]),
      .pol(r_pol[i]), .both(r_any[i]), .clr(rd_stat), .pend(pend[i])
    );
  end

  gpio_pad_mux #(.W(N)) u_pad (
    .byp(r_byp), .dir(r_dir), .oe(r_oe), .outv(r_out),
    .alt_out(alt_out), .alt_oe(alt_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_in(alt_in)
  );

  assign irq_o = |(pend & ~r_mask);

  a_r6_enable_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == RG_EN) |=> ((r_mask & $past(wd)) == '0));
  a_r6_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == RG_DIS) |=> ((r_mask & $past(wd)) == $past(wd)));
  a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (idx == RG_EN || idx == RG_DIS) && wd == '0) |=> $stable(r_mask));
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&r_mask) |-> !irq_o);

  if (N < 32) begin : g_upper
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      prdata[31:N] == '0);
  end
endmodule

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 16;
  localparam int ADDR_W = 6;

  localparam logic [5:0] A_BYP = 6'h00, A_DIR = 6'h04, A_OE = 6'h08, A_OUT = 6'h0C,
    A_IN = 6'h10, A_MASK = 6'h14, A_EN = 6'h18, A_DIS = 6'h1C, A_STAT = 6'h20,
    A_TYPE = 6'h24, A_POL = 6'h28, A_ANY = 6'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [NPINS-1:0] pin_in = '0, pin_out, pin_oe, alt_out = '0, alt_oe = '0, alt_in;
  logic irq_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(posedge clk);
    #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(posedge clk);
    #1 psel = 0; penable = 0;
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    check("R1 pin_oe", {16'd0, pin_oe}, 32'd0);
    rd_check("R1 mask", A_MASK, 32'h0000FFFF);
    rd_check("R1 dir", A_DIR, 32'h0000FFFF);
    rd_check("R1 bypass", A_BYP, 32'h0);
    rd_check("R1 status", A_STAT, 32'h0);
    rd_check("R1 type", A_TYPE, 32'h0);
  endtask

  task automatic t_upper;
    wr(A_BYP, 32'hFFFFFFFF);
    rd_check("R2 bypass upper", A_BYP, 32'h0000FFFF);
    wr(A_BYP, 32'h0);
    rd_check("R2 unmapped", 6'h30, 32'h0);
  endtask

  task automatic t_drive;
    wr(A_DIR, 32'h0000FFF0);
    wr(A_OE, 32'h00000005);
    wr(A_OUT, 32'h0000000F);
    @(negedge clk);
    check("R3 pin_oe", {16'd0, pin_oe}, 32'h0005);
    check("R3 pin_out", {16'd0, pin_out}, 32'h000F);
  endtask

  task automatic t_bypass;
    alt_out = 16'hA5A5; alt_oe = 16'h00F0; pin_in = 16'h1234;
    wr(A_BYP, 32'h000000FF);
    @(negedge clk);
    check("R4 pin_out", {16'd0, pin_out}, 32'h00A5);
    check("R4 pin_oe", {16'd0, pin_oe}, 32'h00F0);
    check("R4 alt_in", {16'd0, alt_in}, 32'h0034);
    wr(A_BYP, 32'h0);
    @(negedge clk);
    check("R4 alt_in off", {16'd0, alt_in}, 32'h0);
  endtask

  task automatic t_input;
    @(negedge clk);
    pin_in = 16'hBEEF;
    wait_cycles(3);
    rd_check("R5 input", A_IN, 32'h0000BEEF);
  endtask

  task automatic t_mask;
    wr(A_DIS, 32'h0);
    rd_check("R6 dis zero", A_MASK, 32'h0000FFFF);
    wr(A_EN, 32'h3);
    rd_check("R6 enable", A_MASK, 32'h0000FFFC);
    wr(A_EN, 32'h0);
    rd_check("R6 en zero", A_MASK, 32'h0000FFFC);
    wr(A_DIS, 32'h1);
    rd_check("R6 disable", A_MASK, 32'h0000FFFD);
    wr(A_DIS, 32'hFFFF);
    rd_check("R6 all masked", A_MASK, 32'h0000FFFF);
    rd_check("R6 en reads 0", A_EN, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(A_DIR, 32'hFFFF);
    wr(A_TYPE, 32'h1);
    wr(A_POL, 32'h1);
    @(negedge clk); pin_in = 16'h0;
    wait_cycles(4);
    rd(A_STAT, v);
    rd(A_STAT, v);
    check("R8 idle status", v, 32'h0);
    @(negedge clk); pin_in = 16'h1;
    wait_cycles(4);
    check("R7 masked irq", {31'd0, irq_o}, 32'd0);
    wr(A_EN, 32'h1);
    @(negedge clk);
    check("R7 unmasked irq", {31'd0, irq_o}, 32'd1);
    rd_check("R8 high level", A_STAT, 32'h1);
    rd_check("R8 level re-sets", A_STAT, 32'h1);
    @(negedge clk); pin_in = 16'h0;
    wait_cycles(4);
    rd(A_STAT, v);
    rd_check("R8 level gone", A_STAT, 32'h0);
    @(negedge clk);
    check("R7 irq low", {31'd0, irq_o}, 32'd0);
    wr(A_POL, 32'h0);
    wait_cycles(2);
    rd_check("R8 low level", A_STAT, 32'h1);
    wr(A_DIS, 32'h1);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(A_TYPE, 32'h0);
    wr(A_POL, 32'h2);
    wr(A_ANY, 32'h8);
    wait_cycles(3);
    rd(A_STAT, v);
    rd(A_STAT, v);
    check("R9 idle", v, 32'h0);
    @(negedge clk); pin_in = 16'h000E;
    wait_cycles(4);
    rd_check("R9 rising", A_STAT, 32'h000A);
    rd_check("R9 one-shot", A_STAT, 32'h0);
    @(negedge clk); pin_in = 16'h0;
    wait_cycles(4);
    rd_check("R9 falling", A_STAT, 32'h000C);
  endtask

  task automatic t_coincide;
    logic [31:0] v;
    wr(A_EN, 32'h2);
    @(negedge clk); pin_in = 16'h0002;
    rd(A_STAT, v);
    check("R10 before set", v, 32'h0);
    @(negedge clk);
    check("R10 irq kept", {31'd0, irq_o}, 32'd1);
    rd_check("R10 kept pending", A_STAT, 32'h2);
    rd_check("R10 cleared", A_STAT, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_upper;
    t_drive;
    t_bypass;
    t_input;
    t_mask;
    t_level;
    t_edge;
    t_coincide;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule